// File: doc/BRIEF.md
# Loopback Modem-Status Register

This block holds the modem status byte of a 16450-style serial port while the port runs in its internal loopback mode. The four modem-control outputs in the control byte are fed back as the four modem status inputs. A change on any looped input latches a sticky change flag. Whenever at least one change flag is set, a pending output asks the interrupt logic for a modem-status interrupt.

A clocked update strobe samples the control byte. On that edge each change flag is computed against the status bit held before the edge, and then the status bit is overwritten. The ring-indicator flag has a different rule: it latches only when the looped ring input falls. A read strobe marks a bus read of the status byte. The byte is visible on the output during the read cycle, and the whole register, status and flags together, is zero from the next cycle on.

With loopback off, the status nibble reads as zero and update strobes are ignored. No external modem pins are modelled.

Top module: `msr_loop_top`

## Requirements
- R1: After rst_ni is released, msr_o is 8'h00 and msi_o is 0.
- R2: On a clock edge with upd_i=1 and loop_en_i=1, the control byte bits are copied into the status nibble. mcr_i bit0 (data-terminal-ready) goes to msr_o bit5. mcr_i bit1 (request-to-send) goes to msr_o bit4. mcr_i bit2 (aux output 1) goes to msr_o bit6. mcr_i bit3 (aux output 2) goes to msr_o bit7. The new values are visible from the cycle after that edge.
- R3: On such an update, change flags are set as follows when the new looped value differs from the held status bit. msr_o bit0 tracks bit4, msr_o bit1 tracks bit5, and msr_o bit3 tracks bit7.
- R4: msr_o bit2 is set by an update only when the looped ring value (bit6) goes from 1 to 0. A rise from 0 to 1 leaves it clear.
- R5: Change flags are compared against the status held before the update. An update that repeats the held values sets no new flag.
- R6: A set change flag stays set through later updates and idle cycles until a read.
- R7: While rd_i=1, msr_o shows the current byte. From the next cycle on, all eight bits are zero. If a read and an update fall in the same cycle, the read wins and the update is discarded.
- R8: msi_o is 1 exactly when at least one of msr_o bits 3:0 is 1.
- R9: While loop_en_i=0, msr_o bits 7:4 read 0 and update strobes change nothing. When loop_en_i returns to 1, the earlier status reappears.
- R10: mcr_i bits 7:4 have no effect on msr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_en_i | input | 1 | Loopback mode enable |
| mcr_i | input | 8 | Modem control byte |
| upd_i | input | 1 | Update strobe, samples mcr_i |
| rd_i | input | 1 | Status read strobe, clears the register after the cycle |
| msr_o | output | 8 | Modem status byte |
| msi_o | output | 1 | Modem-status interrupt pending |

## Verification
A wrong status bit shows on msr_o bits 7:4 one cycle after the update that produced it. A wrong change flag appears in the same cycle on msr_o bits 3:0 and on msi_o. A lost or false flag stays visible until the next read, because every flag is sticky. So an error made on any edge can be observed at the next sample point and at every later one up to the read.

The stimulus exercises each control line on its own and walks the ring line through both edge directions. It repeats a value that is already held, and it issues a read in the same cycle as an update, so that a flag compared against the post-update value, or a lost clear priority, shows up as a mismatch in the byte.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned NLINES = 4;
  localparam int unsigned MCR_W  = 8;
  localparam int unsigned MSR_W  = 2 * NLINES;
  // line order: cts, dsr, ri, dcd -> delta bit g, status bit NLINES+g
  localparam int unsigned SRC_BIT   [NLINES] = '{1, 0, 2, 3};
  localparam bit          FALL_ONLY [NLINES] = '{1'b0, 1'b0, 1'b1, 1'b0};
endpackage

// File: rtl/msr_route.sv
module msr_route
  import msr_pkg::*;
(
  input  logic [MCR_W-1:0]  mcr_i,
  output logic [NLINES-1:0] looped_o
);
  for (genvar g = 0; g < NLINES; g++) begin : g_route
    assign looped_o[g] = mcr_i[SRC_BIT[g]];
  end
  logic unused_hi;
  assign unused_hi = ^mcr_i[MCR_W-1:NLINES];
endmodule

// File: rtl/msr_line.sv
module msr_line #(
  parameter bit FALL_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic clr_i,
  input  logic new_i,
  output logic stat_o,
  output logic delta_o
);
  logic hit;

  if (FALL_ONLY) begin : g_fall
    assign hit = stat_o & ~new_i;
  end else begin : g_any
    assign hit = stat_o ^ new_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o  <= 1'b0;
      delta_o <= 1'b0;
    end else if (clr_i) begin
      stat_o  <= 1'b0;
      delta_o <= 1'b0;
    end else if (upd_i) begin
      stat_o  <= new_i;
      delta_o <= delta_o | hit;
    end
  end
endmodule

// File: rtl/msr_loop_top.sv
module msr_loop_top
  import msr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_en_i,
  input  logic [MCR_W-1:0] mcr_i,
  input  logic             upd_i,
  input  logic             rd_i,
  output logic [MSR_W-1:0] msr_o,
  output logic             msi_o
);
  logic [NLINES-1:0] looped, stat, delta;
  logic              upd_eff;

  assign upd_eff = upd_i & loop_en_i;

  msr_route u_route (.mcr_i(mcr_i), .looped_o(looped));

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    msr_line #(.FALL_ONLY(FALL_ONLY[g])) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd_eff),
      .clr_i  (rd_i),
      .new_i  (looped[g]),
      .stat_o (stat[g]),
      .delta_o(delta[g])
    );
  end

  assign msr_o = {stat & {NLINES{loop_en_i}}, delta};
  assign msi_o = |delta;
endmodule

// File: rtl/msr_loop_chk.sv
module msr_loop_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       loop_en_i,
  input logic [7:0] mcr_i,
  input logic       upd_i,
  input logic       rd_i,
  input logic [7:0] msr_o,
  input logic       msi_o
);
  // R2
  mirror_cts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && loop_en_i && !rd_i) |=> (!loop_en_i || msr_o[4] == $past(mcr_i[1])));
  // R4
  teri_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msr_o[2]) |-> ($past(upd_i) && $past(loop_en_i) && !$past(mcr_i[2]) && $past(msr_o[6])));
  // R5
  no_repeat_delta_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && loop_en_i && !rd_i && mcr_i[1] == msr_o[4] && !msr_o[0]) |=> !msr_o[0]);
  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && msr_o[3]) |=> msr_o[3]);
  // R7
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (msr_o == 8'h00));
  // R8
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msi_o) |-> ($past(upd_i) && $past(loop_en_i)));
  // R9
  off_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !loop_en_i && !rd_i) |=> $stable(msr_o[3:0]));
endmodule

bind msr_loop_top msr_loop_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .loop_en_i(loop_en_i), .mcr_i(mcr_i),
  .upd_i(upd_i), .rd_i(rd_i), .msr_o(msr_o), .msi_o(msi_o)
);

// File: tb/msr_loop_top_tb.sv
module msr_loop_top_tb;
  typedef struct packed {
    logic       loop;
    logic       upd;
    logic       rd;
    logic [7:0] mcr;
    logic [7:0] exp;
    logic       msi;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,8'h00,8'h00,1'b0,4'd2},  // R2 idle
    '{1'b1,1'b1,1'b0,8'h01,8'h22,1'b1,4'd3},  // R3 dtr
    '{1'b1,1'b0,1'b1,8'h01,8'h00,1'b0,4'd7},  // R7 read
    '{1'b1,1'b1,1'b0,8'h01,8'h22,1'b1,4'd3},
    '{1'b1,1'b0,1'b1,8'h01,8'h00,1'b0,4'd7},
    '{1'b1,1'b1,1'b0,8'h02,8'h11,1'b1,4'd3},  // R3 rts
    '{1'b1,1'b0,1'b1,8'h02,8'h00,1'b0,4'd7},
    '{1'b1,1'b1,1'b0,8'h04,8'h40,1'b0,4'd4},  // R4 ri rise
    '{1'b1,1'b1,1'b0,8'h00,8'h04,1'b1,4'd4},  // R4 ri fall
    '{1'b1,1'b0,1'b1,8'h00,8'h00,1'b0,4'd7},
    '{1'b1,1'b1,1'b0,8'h08,8'h88,1'b1,4'd3},  // R3 out2
    '{1'b1,1'b1,1'b0,8'h08,8'h88,1'b1,4'd5},  // R5 repeat
    '{1'b1,1'b1,1'b0,8'h00,8'h08,1'b1,4'd6},  // R6 sticky
    '{1'b1,1'b0,1'b1,8'h00,8'h00,1'b0,4'd7},
    '{1'b1,1'b1,1'b0,8'hF0,8'h00,1'b0,4'd10}, // R10 high nibble
    '{1'b1,1'b1,1'b0,8'h0F,8'hFB,1'b1,4'd2},
    '{1'b1,1'b0,1'b0,8'h00,8'hFB,1'b1,4'd6},  // no strobe
    '{1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,4'd7},  // read beats update
    '{1'b1,1'b1,1'b0,8'h0F,8'hFB,1'b1,4'd2},
    '{1'b0,1'b1,1'b0,8'h00,8'h0B,1'b1,4'd9},  // R9 off
    '{1'b1,1'b0,1'b0,8'h00,8'hFB,1'b1,4'd9},
    '{1'b1,1'b1,1'b0,8'h0B,8'hBF,1'b1,4'd4},
    '{1'b1,1'b0,1'b1,8'h0B,8'h00,1'b0,4'd8}   // R8
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       loop_en_i = 1'b0;
  logic [7:0] mcr_i = 8'h00;
  logic       upd_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] msr_o;
  logic       msi_o;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  msr_loop_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .loop_en_i(loop_en_i), .mcr_i(mcr_i),
    .upd_i(upd_i), .rd_i(rd_i), .msr_o(msr_o), .msi_o(msi_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", msr_o, 8'h00);
    chk("R1", {7'd0, msi_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", msr_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      loop_en_i = VEC[i].loop;
      upd_i     = VEC[i].upd;
      rd_i      = VEC[i].rd;
      mcr_i     = VEC[i].mcr;
      @(negedge clk_i);
      chk($sformatf("R%0d", VEC[i].req), msr_o, VEC[i].exp);
      chk("R8", {7'd0, msi_o}, {7'd0, VEC[i].msi});
    end

    // R7: value visible during read cycle
    upd_i = 1'b1; rd_i = 1'b0; mcr_i = 8'h03;
    @(negedge clk_i);
    upd_i = 1'b0; rd_i = 1'b1;
    #1 chk("R7", msr_o, 8'h33);
    @(negedge clk_i);
    rd_i = 1'b0;
    chk("R7", msr_o, 8'h00);

    // R1: reset mid-run clears state
    upd_i = 1'b1; mcr_i = 8'h0F;
    @(negedge clk_i);
    upd_i = 1'b0;
    rst_ni = 1'b0;
    #1 chk("R1", msr_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", msr_o, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule